// File: doc/BRIEF.md
# Register Rename Map with Move Elimination

This block keeps the map from architectural register numbers to physical register tags for an out-of-order core, one instruction per cycle. An ordinary instruction with a destination takes a fresh tag from the free-list allocate port and writes it into the destination's entry. A register-to-register move is finished inside the map. The destination entry receives the tag the source already holds. No tag is allocated, and the instruction is flagged as a no-op so that dispatch drops it before it reaches a reservation station. Several architectural registers can then share one physical tag, so the block counts the references to each tag. It reports a tag as free only when the last reference has been released at commit.

Two register numbers are special. The highest, number 63, always reads as a reserved zero tag (tag 0), and writes to it are discarded. The one below it, number 62, stands for the instruction pointer when it is the base of a load or store. Register 0 and every other number are plain registers.

A two-state controller (INIT, RUN) sequences the block. After reset it stays in INIT and clears one map entry per cycle to the zero tag. When the last entry is cleared it takes the transition INIT→RUN and raises `ready`. It stays in RUN (RUN→RUN) until the next reset. Rename results appear on the outputs one cycle after an accepted instruction.

Top module: `rename_map_elim`

## Requirements
- R1: After reset the controller stays in INIT with `ready` low for exactly NUM_AREGS cycles, then moves to RUN and holds `ready` high. Every register then maps to tag 0.
- R2: An accepted instruction with `in_has_dst`=1 and a destination other than 63 that is not an eliminated move raises `alloc_take` in the same cycle. The next cycle it reports `alloc_tag` on `out_tag_dst` and the destination's previous tag on `out_old_tag`.
- R3: Source tags are looked up before the destination update of the same instruction. All results are registered and `out_valid` pulses in the cycle after acceptance.
- R4: A move whose source is not 62 (`in_is_move`=1, source in `in_src_a`) writes the source's current tag into the destination entry and does not raise `alloc_take`. It reports that tag on `out_tag_dst` with `out_nop`=1.
- R5: A move from a register to itself leaves the map unchanged.
- R6: Register 63 reads as tag 0 on both sources. A write to it raises no `alloc_take` and changes no entry, and `out_tag_dst`/`out_old_tag` report 0.
- R7: A move from register 63 maps the destination to tag 0 and is eliminated (`out_nop`=1).
- R8: Register 62 as `in_src_a` with `in_is_mem`=1 sets `out_a_is_ip`=1 with `out_tag_a`=0. A move from register 62 is not eliminated: it allocates like an ordinary instruction and `out_nop`=0.
- R9: Register 0 renames like any other ordinary register.
- R10: Each nonzero tag counts one reference per map write that installs it. A release on `rel_valid` removes one reference. `free_valid` pulses with that tag in the next cycle only when its count reaches zero. A release of tag 0 has no effect.
- R11: An instruction with `in_has_dst`=0 allocates nothing and changes no map entry. It reports 0 on `out_tag_dst` and `out_old_tag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready | output | 1 | High in RUN; instructions are accepted only then |
| in_valid | input | 1 | Instruction present |
| in_is_move | input | 1 | Instruction is a register move (source in in_src_a) |
| in_is_mem | input | 1 | in_src_a is a load/store base |
| in_has_dst | input | 1 | Instruction writes a destination |
| in_src_a | input | 6 | First source register |
| in_src_b | input | 6 | Second source register |
| in_dst | input | 6 | Destination register |
| alloc_tag | input | 7 | Next free tag offered by the free list |
| alloc_take | output | 1 | alloc_tag is consumed this cycle |
| rel_valid | input | 1 | Release one reference at commit |
| rel_tag | input | 7 | Tag being released |
| out_valid | output | 1 | Rename result valid |
| out_nop | output | 1 | Instruction was eliminated; dispatch drops it |
| out_a_is_ip | output | 1 | First source is the instruction pointer |
| out_tag_a | output | 7 | Physical tag of first source |
| out_tag_b | output | 7 | Physical tag of second source |
| out_tag_dst | output | 7 | Tag now mapped to the destination |
| out_old_tag | output | 7 | Tag the destination held before |
| free_valid | output | 1 | A tag lost its last reference |
| free_tag | output | 7 | The freed tag |

## Verification
The assertions assume that the free list never offers tag 0 on `alloc_tag`. They also assume that commit never releases a tag that has no reference left. The stimulus keeps both: it draws allocation tags cyclically from 1 to 127 and releases a tag only while the bench's own reference model shows a live count for it. The bench also keeps reference counts far below the counter width, because it sends few writes for each tag before draining every count to zero.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
    typedef enum logic [0:0] {
        ST_INIT = 1'b0,
        ST_RUN  = 1'b1
    } rmap_state_e;
endpackage

// File: rtl/rmap_ctrl.sv
module rmap_ctrl
    import rmap_pkg::*;
#(
    parameter int NUM_AREGS = 64,
    localparam int AW = $clog2(NUM_AREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          ready,
    output logic          clr_we,
    output logic [AW-1:0] clr_idx
);
    localparam logic [AW-1:0] LAST_IDX = AW'(NUM_AREGS - 1);

    rmap_state_e   state_q;
    logic [AW-1:0] idx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_INIT: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == LAST_IDX) state_q <= ST_RUN;
                end
                ST_RUN: state_q <= ST_RUN;
                default: state_q <= ST_INIT;
            endcase
        end
    end

    // outputs
    always_comb begin
        ready   = 1'b0;
        clr_we  = 1'b0;
        clr_idx = idx_q;
        unique case (state_q)
            ST_INIT: clr_we = 1'b1;
            ST_RUN:  ready  = 1'b1;
            default: ;
        endcase
    end

    // R1
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R1
    init_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT && idx_q == LAST_IDX) |=> (state_q == ST_RUN));
endmodule

// File: rtl/rmap_table.sv
module rmap_table #(
    parameter int NUM_AREGS = 64,
    parameter int TW = 7,
    localparam int AW = $clog2(NUM_AREGS)
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_a,
    input  logic [AW-1:0] rd_b,
    input  logic [AW-1:0] rd_d,
    output logic [TW-1:0] tag_a,
    output logic [TW-1:0] tag_b,
    output logic [TW-1:0] tag_d,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [TW-1:0] wdata
);
    localparam logic [AW-1:0] ZREG = AW'(NUM_AREGS - 1);

    logic [TW-1:0] map_q [NUM_AREGS];

    always_ff @(posedge clk) begin
        if (we) map_q[waddr] <= wdata;
    end

    // reads see the map before this cycle's write
    always_comb begin
        tag_a = (rd_a == ZREG) ? '0 : map_q[rd_a];
        tag_b = (rd_b == ZREG) ? '0 : map_q[rd_b];
        tag_d = (rd_d == ZREG) ? '0 : map_q[rd_d];
    end
endmodule

// File: rtl/rmap_refcnt.sv
module rmap_refcnt #(
    parameter int NUM_TAGS = 128,
    parameter int CW = 8,
    localparam int TW = $clog2(NUM_TAGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_en,
    input  logic [TW-1:0] inc_tag,
    input  logic          dec_en,
    input  logic [TW-1:0] dec_tag,
    output logic          free_valid,
    output logic [TW-1:0] free_tag
);
    logic [CW-1:0] cnt_q [NUM_TAGS];
    logic inc_hit, dec_hit, same_tag;

    always_comb begin
        inc_hit  = inc_en && (inc_tag != '0);
        dec_hit  = dec_en && (dec_tag != '0);
        same_tag = inc_hit && dec_hit && (inc_tag == dec_tag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_TAGS; t++) cnt_q[t] <= '0;
            free_valid <= 1'b0;
            free_tag   <= '0;
        end else begin
            for (int t = 1; t < NUM_TAGS; t++) begin
                if (!same_tag) begin
                    if (inc_hit && inc_tag == TW'(t))
                        cnt_q[t] <= cnt_q[t] + 1'b1;
                    else if (dec_hit && dec_tag == TW'(t))
                        cnt_q[t] <= cnt_q[t] - 1'b1;
                end
            end
            free_valid <= dec_hit && !same_tag && (cnt_q[dec_tag] == CW'(1));
            free_tag   <= dec_tag;
        end
    end

    // R10
    release_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_hit && !same_tag) |-> (cnt_q[dec_tag] != '0));

    // R10
    freed_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |-> (free_tag != '0 && cnt_q[free_tag] == '0));
endmodule

// File: rtl/rename_map_elim.sv
module rename_map_elim #(
    parameter int NUM_AREGS = 64,
    parameter int NUM_TAGS  = 128,
    parameter int CNT_W     = 8,
    localparam int AW = $clog2(NUM_AREGS),
    localparam int TW = $clog2(NUM_TAGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          ready,
    input  logic          in_valid,
    input  logic          in_is_move,
    input  logic          in_is_mem,
    input  logic          in_has_dst,
    input  logic [AW-1:0] in_src_a,
    input  logic [AW-1:0] in_src_b,
    input  logic [AW-1:0] in_dst,
    input  logic [TW-1:0] alloc_tag,
    output logic          alloc_take,
    input  logic          rel_valid,
    input  logic [TW-1:0] rel_tag,
    output logic          out_valid,
    output logic          out_nop,
    output logic          out_a_is_ip,
    output logic [TW-1:0] out_tag_a,
    output logic [TW-1:0] out_tag_b,
    output logic [TW-1:0] out_tag_dst,
    output logic [TW-1:0] out_old_tag,
    output logic          free_valid,
    output logic [TW-1:0] free_tag
);
    localparam logic [AW-1:0] ZERO_REG = AW'(NUM_AREGS - 1);
    localparam logic [AW-1:0] IP_REG   = AW'(NUM_AREGS - 2);

    logic          clr_we;
    logic [AW-1:0] clr_idx;
    logic [TW-1:0] tag_a, tag_b, tag_d, new_tag;
    logic          fire, ip_src, elim, writes;
    logic          map_we;
    logic [AW-1:0] map_waddr;
    logic [TW-1:0] map_wdata;

    rmap_ctrl #(.NUM_AREGS(NUM_AREGS)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ready  (ready),
        .clr_we (clr_we),
        .clr_idx(clr_idx)
    );

    always_comb begin
        fire       = in_valid && ready;
        ip_src     = (in_src_a == IP_REG);
        elim       = in_is_move && !ip_src;
        writes     = in_has_dst && (in_dst != ZERO_REG);
        new_tag    = elim ? tag_a : alloc_tag;
        alloc_take = fire && writes && !elim;
        map_we     = clr_we || (fire && writes);
        map_waddr  = clr_we ? clr_idx : in_dst;
        map_wdata  = clr_we ? '0 : new_tag;
    end

    rmap_table #(.NUM_AREGS(NUM_AREGS), .TW(TW)) u_table (
        .clk  (clk),
        .rd_a (in_src_a),
        .rd_b (in_src_b),
        .rd_d (in_dst),
        .tag_a(tag_a),
        .tag_b(tag_b),
        .tag_d(tag_d),
        .we   (map_we),
        .waddr(map_waddr),
        .wdata(map_wdata)
    );

    rmap_refcnt #(.NUM_TAGS(NUM_TAGS), .CW(CNT_W)) u_refcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_en    (fire && writes),
        .inc_tag   (new_tag),
        .dec_en    (rel_valid),
        .dec_tag   (rel_tag),
        .free_valid(free_valid),
        .free_tag  (free_tag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_nop     <= 1'b0;
            out_a_is_ip <= 1'b0;
            out_tag_a   <= '0;
            out_tag_b   <= '0;
            out_tag_dst <= '0;
            out_old_tag <= '0;
        end else begin
            out_valid   <= fire;
            out_nop     <= fire && elim;
            out_a_is_ip <= fire && in_is_mem && ip_src;
            out_tag_a   <= (in_is_mem && ip_src) ? '0 : tag_a;
            out_tag_b   <= tag_b;
            out_tag_dst <= writes ? new_tag : '0;
            out_old_tag <= writes ? tag_d : '0;
        end
    end

    // R2
    alloc_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_take |-> ready);

    // R4
    nop_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_nop |-> (out_valid && !$past(alloc_take)));

    // R6
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_src_b == ZERO_REG)) |-> (out_tag_b == '0));

    // R8
    ip_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_a_is_ip |-> (out_tag_a == '0 && !out_nop));

    // R2
    alloc_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_take |-> (alloc_tag != '0));
endmodule

// File: tb/tb_rename_map_elim.sv
module tb_rename_map_elim;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ready;
    logic       in_valid = 0, in_is_move = 0, in_is_mem = 0, in_has_dst = 0;
    logic [5:0] in_src_a = 0, in_src_b = 0, in_dst = 0;
    logic [6:0] alloc_tag = 7'd1;
    logic       alloc_take;
    logic       rel_valid = 0;
    logic [6:0] rel_tag = 0;
    logic       out_valid, out_nop, out_a_is_ip;
    logic [6:0] out_tag_a, out_tag_b, out_tag_dst, out_old_tag;
    logic       free_valid;
    logic [6:0] free_tag;

    int n_chk = 0, n_bad = 0;
    int mm [64];
    int cnt [128];
    int nxt = 1;
    bit done = 0;

    always #5 clk = ~clk;

    rename_map_elim dut (
        .clk(clk), .rst_n(rst_n), .ready(ready),
        .in_valid(in_valid), .in_is_move(in_is_move), .in_is_mem(in_is_mem),
        .in_has_dst(in_has_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .in_dst(in_dst), .alloc_tag(alloc_tag), .alloc_take(alloc_take),
        .rel_valid(rel_valid), .rel_tag(rel_tag),
        .out_valid(out_valid), .out_nop(out_nop), .out_a_is_ip(out_a_is_ip),
        .out_tag_a(out_tag_a), .out_tag_b(out_tag_b), .out_tag_dst(out_tag_dst),
        .out_old_tag(out_old_tag), .free_valid(free_valid), .free_tag(free_tag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one instruction: expected values from the requirements, then model update
    task automatic ren(input bit mv, input bit mem, input bit hd,
                       input int a, input int b, input int d, input string req);
        bit ip, elim, wr, need;
        int ta, tb, nt, old;
        ip   = (a == 62);
        elim = mv && !ip;
        wr   = hd && (d != 63);
        need = wr && !elim;
        ta   = (a == 63) ? 0 : mm[a];
        tb   = (b == 63) ? 0 : mm[b];
        old  = (d == 63) ? 0 : mm[d];
        nt   = elim ? ta : nxt;
        @(negedge clk);
        in_valid = 1; in_is_move = mv; in_is_mem = mem; in_has_dst = hd;
        in_src_a = 6'(a); in_src_b = 6'(b); in_dst = 6'(d);
        alloc_tag = 7'(nxt);
        #1;
        chk({req, " alloc_take"}, int'(alloc_take), int'(need));
        @(posedge clk);
        #1;
        in_valid = 0;
        chk({req, " out_valid"}, int'(out_valid), 1);
        chk({req, " out_nop"}, int'(out_nop), int'(elim));
        chk({req, " out_a_is_ip"}, int'(out_a_is_ip), int'(mem && ip));
        chk({req, " out_tag_a"}, int'(out_tag_a), (mem && ip) ? 0 : ta);
        chk({req, " out_tag_b"}, int'(out_tag_b), tb);
        chk({req, " out_tag_dst"}, int'(out_tag_dst), wr ? nt : 0);
        chk({req, " out_old_tag"}, int'(out_old_tag), wr ? old : 0);
        if (wr) begin
            mm[d] = nt;
            if (nt != 0) cnt[nt]++;
        end
        if (need) nxt = (nxt % 127) + 1;
    endtask

    task automatic rel(input int t, input string req);
        bit ef;
        ef = (t != 0) && (cnt[t] == 1);
        @(negedge clk);
        rel_valid = 1; rel_tag = 7'(t);
        @(posedge clk);
        #1;
        rel_valid = 0;
        chk({req, " free_valid"}, int'(free_valid), int'(ef));
        if (ef) chk({req, " free_tag"}, int'(free_tag), t);
        if (t != 0 && cnt[t] > 0) cnt[t]--;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int wait_cyc;
        for (int i = 0; i < 64; i++) mm[i] = 0;
        for (int t = 0; t < 128; t++) cnt[t] = 0;
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", int'(ready), 0);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        rst_n = 1;
        wait_cyc = 0;
        while (!ready && wait_cyc < 200) begin
            @(negedge clk);
            wait_cyc++;
        end
        chk("R1 init length", wait_cyc, 64);

        // R1: every register reads tag 0 after init
        for (int i = 0; i < 64; i++) ren(0, 0, 0, i, 63 - i, 0, "R1 reset map");
        // R2 R3 R9: ordinary writes, source equal to destination reads old tag
        for (int i = 0; i < 63; i++) ren(0, 0, 1, i, (i + 1) % 64, i, "R2 alloc write");
        ren(0, 0, 1, 0, 1, 0, "R9 reg0 rewrite");
        for (int i = 0; i < 64; i++) ren(0, 0, 0, i, i, 0, "R3 readback");
        // R6: writes to 63 ignored
        ren(0, 0, 1, 5, 63, 63, "R6 write zero reg");
        ren(1, 0, 1, 4, 0, 63, "R6 move to zero reg");
        ren(0, 0, 0, 63, 63, 0, "R6 read zero reg");
        // R11: no destination
        ren(0, 0, 0, 7, 8, 7, "R11 no dst");
        ren(0, 0, 0, 7, 7, 0, "R11 readback");
        // R4: move sweep
        for (int d = 0; d < 62; d++) ren(1, 0, 1, (d + 7) % 62, d, d, "R4 move");
        for (int i = 0; i < 64; i++) ren(0, 0, 0, i, 63 - i, 0, "R4 readback");
        // R5: self move
        ren(1, 0, 1, 10, 0, 10, "R5 self move");
        ren(0, 0, 0, 10, 10, 0, "R5 readback");
        // R7: move from zero register
        ren(1, 0, 1, 63, 0, 20, "R7 move from zero");
        ren(0, 0, 0, 20, 20, 0, "R7 readback");
        // R8: instruction pointer base and move from 62
        ren(0, 1, 0, 62, 3, 0, "R8 ip base");
        ren(0, 0, 0, 62, 3, 0, "R8 r62 plain source");
        ren(1, 0, 1, 62, 0, 30, "R8 move from ip");
        ren(0, 0, 0, 30, 62, 0, "R8 readback");
        // R10: shared tag freed only after last release
        ren(0, 0, 1, 0, 0, 40, "R10 alloc");
        ren(1, 0, 1, 40, 0, 41, "R10 share");
        rel(0, "R10 release zero tag");
        for (int t = 1; t < 128; t++) begin
            while (cnt[t] > 0) rel(t, "R10 drain");
        end
        rel(0, "R10 release zero tag again");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule